// File: doc/BRIEF.md
# Pipelined Execute Unit with Result Feedback

This block is the execute stage of a small in-order soft processor. It is built like a multiply-add arithmetic slice. Each issued instruction carries the following:

- an operation code: add, subtract or multiply;
- two register-file operands: a 30-bit A and an 18-bit B, which are concatenated into a 48-bit X for add and subtract;
- a 48-bit C value;
- a destination tag;
- two per-instruction control bits.

The first control bit makes the unit's own previous result stand in for C. The second keeps the new result inside the unit instead of sending it to writeback.

Every instruction passes through the same number of register stages, set at build time from one to five. The add, subtract and result-select logic sits in the final stage, directly in front of the result register, and that register feeds back into the final stage. As a result, an add or subtract that depends on the instruction issued just before it can be issued on the very next cycle, at any depth, with no idle slots. A multiply always produces the signed product of the low 25 bits of A and all of B; it never consumes the fed-back value.

Bubbles (cycles with no valid instruction) pass through the stages without touching the result register. A consumer issued after a gap therefore still sees the last real result. The writeback side receives the result, the destination tag and a write enable. Results marked as feedback-only raise no write enable.

Top module: `exu_loopback_alu`

## Requirements
- R1: While reset is asserted, and until the first valid instruction reaches the end of the pipeline, out_wr_en is 0 and out_result is 0.
- R2: An instruction with op code 0 (add; the unused code 3 also adds) that has in_valid=1 at a rising edge produces out_result = C + {A,B} modulo 2^48, where A forms the upper 30 bits of the concatenation. The result becomes visible after the EX_STAGES-th rising edge, counting the issuing edge as the first.
- R3: Op code 1 (subtract) produces C - {A,B} modulo 2^48, with the same latency as R2.
- R4: Op code 2 (multiply) produces the signed product of A[24:0] and B, sign-extended to 48 bits, with the same latency as R2.
- R5: For an add or subtract with in_fb_src=1, the value of the most recent valid result replaces C.
- R6: A chain of dependent add/subtract instructions issued on consecutive cycles, each with in_fb_src=1, computes every link correctly at every depth from 1 to 5, with no idle cycle between links.
- R7: For a multiply, in_fb_src has no effect on the result.
- R8: out_wr_en is 1 for exactly one cycle per valid instruction with in_fb_dst=0. It stays 0 for instructions with in_fb_dst=1, although their result still feeds the next consumer.
- R9: A cycle with in_valid=0 leaves out_result and the fed-back value unchanged and raises no write enable, whatever the other inputs carry.
- R10: Whenever out_wr_en is 1, out_dst equals the in_dst of the instruction whose result is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 add |
| in_a | input | A_W (30) | Register operand A, upper part of X |
| in_b | input | B_W (18) | Register operand B, lower part of X |
| in_c | input | C_W (48) | Addend/minuend C |
| in_fb_src | input | 1 | Use previous result in place of C (add/subtract only) |
| in_fb_dst | input | 1 | Result goes only to the feedback path |
| in_dst | input | TAG_W (5) | Destination register tag |
| out_result | output | C_W (48) | Result register, also the feedback value |
| out_dst | output | TAG_W (5) | Tag of the shown result |
| out_wr_en | output | 1 | Writeback request |

## Verification
The result register does two jobs in the same cycle. It presents a producer's value to writeback, and at that same moment it feeds the dependent instruction that has just reached the final stage. The test provokes this with back-to-back dependent chains at all five depths at once. Some producers write a real register and others are feedback-only, and bubbles with garbage operands are placed inside the chains. Each depth's outputs are compared every cycle with a one-instruction-at-a-time reference model, shifted by that depth's latency. A wrong producer value is therefore caught both at the writeback port and in the consumer's later result.

// File: rtl/exu_pkg.sv
package exu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_RSV = 2'd3
   } exu_op_e;

   localparam int EXU_MAX_STAGES = 5;
endpackage

// File: rtl/exu_operand_prep.sv
module exu_operand_prep
   import exu_pkg::*;
#(
   parameter int A_W  = 30,
   parameter int B_W  = 18,
   parameter int C_W  = 48,
   parameter int MA_W = 25
) (
   input  logic [1:0]     op,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic [C_W-1:0] x
);
   localparam int PR_W = MA_W + B_W;

   logic signed [MA_W-1:0] a_lo;
   logic signed [B_W-1:0]  b_s;
   logic signed [PR_W-1:0] prod;

   assign a_lo = a[MA_W-1:0];
   assign b_s  = b;
   assign prod = a_lo * b_s;

   always_comb begin
      if (exu_op_e'(op) == OP_MUL) x = C_W'(prod);
      else                         x = {a, b};
   end
endmodule

// File: rtl/exu_delay_line.sv
module exu_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/exu_accum_stage.sv
module exu_accum_stage
   import exu_pkg::*;
#(
   parameter int C_W   = 48,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [1:0]       op,
   input  logic             fb_src,
   input  logic             fb_dst,
   input  logic [TAG_W-1:0] dst,
   input  logic [C_W-1:0]   c,
   input  logic [C_W-1:0]   x,
   output logic [C_W-1:0]   result,
   output logic [TAG_W-1:0] result_dst,
   output logic             wr_en
);
   logic [C_W-1:0]   p_q;
   logic [TAG_W-1:0] dst_q;
   logic             wr_q;
   logic [C_W-1:0]   z_sel;
   logic [C_W-1:0]   p_nxt;
   exu_op_e          op_e;

   assign op_e = exu_op_e'(op);

   always_comb begin
      z_sel = (fb_src && op_e != OP_MUL) ? p_q : c;
      unique case (op_e)
         OP_MUL:  p_nxt = x;
         OP_SUB:  p_nxt = z_sel - x;
         default: p_nxt = z_sel + x;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q   <= '0;
         dst_q <= '0;
         wr_q  <= 1'b0;
      end else begin
         wr_q <= valid && !fb_dst;
         if (valid) begin
            p_q   <= p_nxt;
            dst_q <= dst;
         end
      end
   end

   assign result     = p_q;
   assign result_dst = dst_q;
   assign wr_en      = wr_q;
endmodule

// File: rtl/exu_loopback_alu.sv
module exu_loopback_alu
   import exu_pkg::*;
#(
   parameter int EX_STAGES = 3,
   parameter int A_W       = 30,
   parameter int B_W       = 18,
   parameter int C_W       = 48,
   parameter int MA_W      = 25,
   parameter int TAG_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic [A_W-1:0]   in_a,
   input  logic [B_W-1:0]   in_b,
   input  logic [C_W-1:0]   in_c,
   input  logic             in_fb_src,
   input  logic             in_fb_dst,
   input  logic [TAG_W-1:0] in_dst,
   output logic [C_W-1:0]   out_result,
   output logic [TAG_W-1:0] out_dst,
   output logic             out_wr_en
);
   localparam int PL_W    = 1 + 2 + 1 + 1 + TAG_W + 2 * C_W;
   localparam int PRE_STG = EX_STAGES - 1;

   if (EX_STAGES < 1 || EX_STAGES > EXU_MAX_STAGES)
      $error("exu_loopback_alu: EX_STAGES out of range");
   if (A_W + B_W != C_W)
      $error("exu_loopback_alu: A_W + B_W must equal C_W");
   if (MA_W > A_W || MA_W + B_W > C_W)
      $error("exu_loopback_alu: product does not fit");

   logic [C_W-1:0]   x_w;
   logic [PL_W-1:0]  pl_in;
   logic [PL_W-1:0]  pl_out;
   logic             s_valid, s_fb_src, s_fb_dst;
   logic [1:0]       s_op;
   logic [TAG_W-1:0] s_dst;
   logic [C_W-1:0]   s_c, s_x;

   exu_operand_prep #(.A_W(A_W), .B_W(B_W), .C_W(C_W), .MA_W(MA_W)) prep_i (
      .op (in_op),
      .a  (in_a),
      .b  (in_b),
      .x  (x_w)
   );

   assign pl_in = {in_valid, in_op, in_fb_src, in_fb_dst, in_dst, in_c, x_w};

   if (PRE_STG == 0) begin : g_direct
      assign pl_out = pl_in;
   end else begin : g_piped
      exu_delay_line #(.W(PL_W), .DEPTH(PRE_STG)) dly_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pl_in),
         .q     (pl_out)
      );
   end

   assign {s_valid, s_op, s_fb_src, s_fb_dst, s_dst, s_c, s_x} = pl_out;

   exu_accum_stage #(.C_W(C_W), .TAG_W(TAG_W)) acc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (s_valid),
      .op         (s_op),
      .fb_src     (s_fb_src),
      .fb_dst     (s_fb_dst),
      .dst        (s_dst),
      .c          (s_c),
      .x          (s_x),
      .result     (out_result),
      .result_dst (out_dst),
      .wr_en      (out_wr_en)
   );
endmodule

// File: rtl/exu_loopback_alu_chk.sv
module exu_loopback_alu_chk #(
   parameter int EX_STAGES = 3,
   parameter int C_W       = 48,
   parameter int TAG_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_fb_dst,
   input logic [TAG_W-1:0] in_dst,
   input logic [C_W-1:0]   out_result,
   input logic [TAG_W-1:0] out_dst,
   input logic             out_wr_en
);
   localparam int LAST = EX_STAGES - 1;

   logic             v_trk  [EX_STAGES];
   logic             nd_trk [EX_STAGES];
   logic [TAG_W-1:0] d_trk  [EX_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < EX_STAGES; i++) begin
            v_trk[i]  <= 1'b0;
            nd_trk[i] <= 1'b0;
            d_trk[i]  <= '0;
         end
      end else begin
         v_trk[0]  <= in_valid;
         nd_trk[0] <= in_fb_dst;
         d_trk[0]  <= in_dst;
         for (int i = 1; i < EX_STAGES; i++) begin
            v_trk[i]  <= v_trk[i-1];
            nd_trk[i] <= nd_trk[i-1];
            d_trk[i]  <= d_trk[i-1];
         end
      end
   end

   assert_hold_on_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !v_trk[LAST] |-> $stable(out_result));

   assert_no_write_on_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !v_trk[LAST] |-> !out_wr_en);

   assert_write_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en == (v_trk[LAST] && !nd_trk[LAST]));

   assert_tag_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> out_dst == d_trk[LAST]);
endmodule

bind exu_loopback_alu exu_loopback_alu_chk #(
   .EX_STAGES (EX_STAGES),
   .C_W       (C_W),
   .TAG_W     (TAG_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_fb_dst  (in_fb_dst),
   .in_dst     (in_dst),
   .out_result (out_result),
   .out_dst    (out_dst),
   .out_wr_en  (out_wr_en)
);

// File: tb/exu_loopback_alu_tb_top.sv
`timescale 1ns/1ps
module exu_loopback_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'd0;
   logic [29:0] in_a = '0;
   logic [17:0] in_b = '0;
   logic [47:0] in_c = '0;
   logic        in_fb_src = 1'b0;
   logic        in_fb_dst = 1'b0;
   logic [4:0]  in_dst = '0;

   logic [47:0] res_o [1:5];
   logic [4:0]  dst_o [1:5];
   logic        wr_o  [1:5];

   int vectors = 0;
   int fails   = 0;

   logic [47:0] lp_m = '0;
   logic [47:0] hres [0:4];
   logic [4:0]  hdst [0:4];
   logic        hwr  [0:4];
   string       htag [0:4];

   always #10 clk = ~clk;

   for (genvar d = 1; d <= 5; d++) begin : g_dep
      exu_loopback_alu #(.EX_STAGES(d)) dut_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .in_valid   (in_valid),
         .in_op      (in_op),
         .in_a       (in_a),
         .in_b       (in_b),
         .in_c       (in_c),
         .in_fb_src  (in_fb_src),
         .in_fb_dst  (in_fb_dst),
         .in_dst     (in_dst),
         .out_result (res_o[d]),
         .out_dst    (dst_o[d]),
         .out_wr_en  (wr_o[d])
      );
   end

   function automatic logic [47:0] ref_exec(input logic [1:0] op, input logic [29:0] a,
                                            input logic [17:0] b, input logic [47:0] c,
                                            input logic fs, input logic [47:0] lp);
      logic signed [47:0] ma, mb, z;
      ma = {{23{a[24]}}, a[24:0]};
      mb = {{30{b[17]}}, b};
      if (op == 2'd2) return ma * mb;
      z = fs ? lp : c;
      if (op == 2'd1) return z - {a, b};
      return z + {a, b};
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic check_all();
      for (int d = 1; d <= 5; d++) begin
         vectors++;
         if (res_o[d] !== hres[d-1] || wr_o[d] !== hwr[d-1] ||
             (hwr[d-1] && dst_o[d] !== hdst[d-1])) begin
            fails++;
            $display("FAIL %s depth %0d: actual res=%h wr=%b dst=%0d expected res=%h wr=%b dst=%0d",
                     htag[d-1], d, res_o[d], wr_o[d], dst_o[d], hres[d-1], hwr[d-1], hdst[d-1]);
         end
      end
   endtask

   // Drive one slot at a negedge, advance one clock, check all depths at the next negedge.
   task automatic issue(input logic v, input logic [1:0] op, input logic [29:0] a,
                        input logic [17:0] b, input logic [47:0] c, input logic fs,
                        input logic fd, input logic [4:0] dst, input string tag);
      in_valid = v; in_op = op; in_a = a; in_b = b; in_c = c;
      in_fb_src = fs; in_fb_dst = fd; in_dst = dst;
      if (v) lp_m = ref_exec(op, a, b, c, fs, lp_m);
      @(posedge clk);
      #1;
      for (int i = 4; i > 0; i--) begin
         hres[i] = hres[i-1]; hdst[i] = hdst[i-1]; hwr[i] = hwr[i-1]; htag[i] = htag[i-1];
      end
      hres[0] = lp_m; hdst[0] = dst; hwr[0] = v && !fd; htag[0] = tag;
      @(negedge clk);
      check_all();
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++)
         issue(1'b0, $urandom, $urandom, $urandom, {$urandom, $urandom}, $urandom, 1'b0, $urandom, tag);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 5; i++) begin
         hres[i] = '0; hdst[i] = '0; hwr[i] = 1'b0; htag[i] = "R1";
      end
      rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check_all();   // R1 outputs quiet under reset
      end
      rst_n = 1'b1;
      idle(5, "R1");
   endtask

   task automatic t_basic_ops();
      issue(1, 2'd0, 30'h0000_0003, 18'h00005, 48'd100, 0, 0, 5'd1, "R2 add");
      issue(1, 2'd0, 30'h3FFF_FFFF, 18'h3FFFF, 48'd7, 0, 0, 5'd2, "R2 add wrap");
      issue(1, 2'd3, 30'h0000_0001, 18'h00000, 48'd9, 0, 0, 5'd3, "R2 code3 add");
      issue(1, 2'd1, 30'h0000_0000, 18'h00010, 48'd5, 0, 0, 5'd4, "R3 sub");
      issue(1, 2'd1, 30'h0123_4567, 18'h0ABCD, 48'h8000_0000_0000, 0, 0, 5'd5, "R3 sub");
      issue(1, 2'd2, 30'h0000_0007, 18'h00006, 48'd0, 0, 0, 5'd6, "R4 mul");
      issue(1, 2'd2, 30'h01FF_FFFF, 18'h00003, 48'd0, 0, 0, 5'd7, "R4 mul neg a");
      issue(1, 2'd2, 30'h2100_0002, 18'h20000, 48'd0, 0, 0, 5'd8, "R4 mul neg b hi bits");
      issue(1, 2'd0, 30'h1, 18'h2, 48'd3, 0, 0, 5'd31, "R10 tag");
      idle(5, "R2 drain");
   endtask

   task automatic t_loop_basic();
      issue(1, 2'd0, 30'h0, 18'h00010, 48'd1000, 0, 0, 5'd9, "R5 producer");
      issue(1, 2'd0, 30'h0, 18'h00001, 48'hDEAD, 1, 0, 5'd10, "R5 add from loop");
      issue(1, 2'd1, 30'h0, 18'h00100, 48'hBEEF, 1, 0, 5'd11, "R5 sub from loop");
      issue(1, 2'd2, 30'h0, 18'h00004, 48'd0, 0, 1, 5'd0, "R5 mul producer");
      issue(1, 2'd0, 30'h0, 18'h00002, 48'd77, 1, 0, 5'd12, "R5 add after mul");
      idle(5, "R5 drain");
   endtask

   task automatic t_chain();
      for (int n = 0; n < 40; n++)
         issue(1, {1'b0, 1'($urandom)}, $urandom, $urandom, {$urandom, $urandom},
               (n != 0), 1'($urandom), 5'($urandom), "R6 chain");
      idle(5, "R6 drain");
   endtask

   task automatic t_mul_fb();
      issue(1, 2'd0, 30'h0, 18'h3, 48'd500, 0, 0, 5'd13, "R7 producer");
      issue(1, 2'd2, 30'h0000_0005, 18'h3FFFE, 48'd1, 1, 0, 5'd14, "R7 mul fb ignored");
      issue(1, 2'd2, 30'h0000_0009, 18'h00009, 48'd2, 1, 0, 5'd15, "R7 mul fb ignored");
      idle(5, "R7 drain");
   endtask

   task automatic t_loop_dst();
      issue(1, 2'd0, 30'h0, 18'h00021, 48'd40, 0, 1, 5'd16, "R8 feedback-only");
      issue(1, 2'd1, 30'h0, 18'h00003, 48'd999, 1, 1, 5'd17, "R8 feedback-only");
      issue(1, 2'd0, 30'h0, 18'h00001, 48'd888, 1, 0, 5'd18, "R8 consumer writes");
      idle(5, "R8 drain");
   endtask

   task automatic t_bubble();
      issue(1, 2'd0, 30'h0, 18'h00444, 48'h1234_5678, 0, 0, 5'd19, "R9 producer");
      idle(3, "R9 bubble");
      issue(1, 2'd0, 30'h0, 18'h00001, 48'hFFFF, 1, 0, 5'd20, "R9 consumer after gap");
      issue(1, 2'd1, 30'h0, 18'h00002, 48'h0, 1, 1, 5'd21, "R9 loop-only");
      issue(0, 2'd0, 30'h3FFF_FFFF, 18'h3FFFF, 48'hFFFF_FFFF_FFFF, 1, 0, 5'd22, "R9 bubble");
      issue(1, 2'd0, 30'h0, 18'h00005, 48'h0, 1, 0, 5'd23, "R9 consumer after gap");
      idle(6, "R9 drain");
   endtask

   initial begin
      t_reset();
      t_basic_ops();
      t_loop_basic();
      t_chain();
      t_mul_fb();
      t_loop_dst();
      t_bubble();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end
endmodule